// File: doc/BRIEF.md
# Multi-CPU Level Interrupt Controller

This block collects level-sensitive interrupt sources and presents them to up to four CPUs. Software reaches it through one register bus with two windows. The global window holds the source enables, one routing word per source and a read-only control word. The per-CPU window holds each CPU's mask and its acknowledge register. A CPU-index input picks which CPU's per-CPU window an access reaches. Enables and masks are changed by writing a source number to a set register or a clear register, so a write never has to read, modify and write back a shared bitmap.

Each CPU reads its acknowledge register to learn what to service. The register returns identifier 0 when that CPU's doorbell is raised. Otherwise it returns the lowest-numbered source pending for that CPU, or 1023 when nothing is pending. Sources are level inputs, so reading the acknowledge register changes no state. A source stays pending until its input drops or until software disables or masks it. One source number is reserved for a per-CPU timer. The timer is gated only by each CPU's own mask and not by the global enable or the routing word. Each CPU also has an interrupt output, which is the "something pending" summary of its acknowledge register.

Top module: `mcic_top`

## Requirements
- R1: After reset all global enables are clear, every source is masked for every CPU and every routing word reads 0. With any input pattern and no doorbell, every irq output is low and every acknowledge read returns 1023.
- R2: A global write of source number n to offset 0x30 sets the enable of source n, and a write of n to offset 0x34 clears it. The enables of all other sources keep their values.
- R3: The routing word of source n is at global offset 0x100 + 4*n. Bit c (bits [NUM_CPUS-1:0]) routes the source to CPU c, and the word reads back with all other bits zero. A source is never pending for a CPU whose routing bit is 0.
- R4: A per-CPU write of n to offset 0x48 masks source n for the CPU named by the CPU-index input, and a write of n to offset 0x4C unmasks it. The masks of the other CPUs are not affected.
- R5: An ordinary source is pending for CPU c exactly while its input is high, it is enabled, it is routed to c and it is unmasked for c. When the input drops, the source stops being pending.
- R6: The timer source (TIMER_SRC, default 5) is pending for CPU c whenever its input is high and it is unmasked for c. Its enable and routing word have no effect.
- R7: While doorbell input c is high, a read of per-CPU offset 0x44 for CPU c returns identifier 0, whatever sources are pending.
- R8: With no doorbell raised, a read of offset 0x44 returns in bits [9:0] the lowest-numbered source pending for that CPU, or 1023 if there is none. Bits [31:10] are zero.
- R9: Output cpu_irq_o[c] is high exactly when an acknowledge read for CPU c would return a value other than 1023.
- R10: A global read of offset 0x00 returns NUM_SRCS in bits [11:2].
- R11: Every read request is answered with rd_valid high for one cycle on the next clock, with rd_data valid in that cycle. A write request produces no response.
- R12: Source input 0 never becomes pending, because identifier 0 is reserved for the doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_percpu | input | 1 | 1 = per-CPU window, 0 = global window |
| bus_cpu | input | CPU_W | CPU whose per-CPU window is accessed |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read response strobe |
| rd_data | output | DATA_W | Read response data |
| src_i | input | NUM_SRCS | Level source inputs, bit n = source n |
| doorbell_i | input | NUM_CPUS | Per-CPU doorbell summary levels |
| cpu_irq_o | output | NUM_CPUS | Per-CPU interrupt request |

## Verification
On every cycle the assertions check the read handshake timing, that a raised doorbell drives its CPU's irq and forces acknowledge value 0, that irq stays low when all inputs are idle, that acknowledge values lie in the legal range and that the control word reports the source count. Whether a particular set or clear write touched only its own source or only the addressed CPU, and whether the lowest pending number wins, can only be seen in the bench's scenarios. Those scenarios compare acknowledge values and irq outputs against expectations built up step by step. The timer's independence from enable and routing is also shown only in the scenarios.

// File: rtl/mcic_pkg.sv
package mcic_pkg;
   localparam int ID_W = 10;
   localparam logic [ID_W-1:0] ID_NONE     = 10'd1023;
   localparam logic [ID_W-1:0] ID_DOORBELL = 10'd0;

   // global window
   localparam int OFS_CTRL   = 'h000;
   localparam int OFS_EN_SET = 'h030;
   localparam int OFS_EN_CLR = 'h034;
   localparam int OFS_ROUTE  = 'h100;
   // per-CPU window
   localparam int OFS_ACK    = 'h044;
   localparam int OFS_MSK_SET = 'h048;
   localparam int OFS_MSK_CLR = 'h04C;
endpackage

// File: rtl/mcic_regs.sv
module mcic_regs
   import mcic_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   parameter int NUM_SRCS = 32,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int CPU_W    = 2,
   parameter int SRC_W    = 5
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr_en,
   input  logic                               bus_percpu,
   input  logic [CPU_W-1:0]                   bus_cpu,
   input  logic [ADDR_W-1:0]                  bus_addr,
   input  logic [DATA_W-1:0]                  bus_wdata,
   output logic [NUM_SRCS-1:0]                en_o,
   output logic [NUM_CPUS-1:0][NUM_SRCS-1:0]  mask_o,
   output logic [NUM_SRCS-1:0][NUM_CPUS-1:0]  route_o,
   output logic                               route_hit_o,
   output logic [NUM_CPUS-1:0]                route_sel_o
);
   localparam int ROUTE_SPAN = 4 * NUM_SRCS;

   logic [ADDR_W-1:0] route_off;
   logic [SRC_W-1:0]  route_idx;
   logic [SRC_W-1:0]  wr_idx;
   logic              idx_ok;
   logic              cpu_ok;

   assign route_off   = bus_addr - ADDR_W'(OFS_ROUTE);
   assign route_hit_o = (bus_addr >= ADDR_W'(OFS_ROUTE)) &&
                        (route_off < ADDR_W'(ROUTE_SPAN)) &&
                        (route_off[1:0] == 2'b00);
   assign route_idx   = route_off[SRC_W+1:2];
   assign route_sel_o = route_hit_o ? route_o[route_idx] : '0;

   assign idx_ok = (bus_wdata < DATA_W'(NUM_SRCS));
   assign wr_idx = bus_wdata[SRC_W-1:0];
   assign cpu_ok = (int'(bus_cpu) < NUM_CPUS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_o    <= '0;
         mask_o  <= '1;
         route_o <= '0;
      end else if (wr_en) begin
         if (!bus_percpu) begin
            if (bus_addr == ADDR_W'(OFS_EN_SET) && idx_ok) en_o[wr_idx] <= 1'b1;
            if (bus_addr == ADDR_W'(OFS_EN_CLR) && idx_ok) en_o[wr_idx] <= 1'b0;
            if (route_hit_o) route_o[route_idx] <= bus_wdata[NUM_CPUS-1:0];
         end else if (cpu_ok && idx_ok) begin
            if (bus_addr == ADDR_W'(OFS_MSK_SET)) mask_o[bus_cpu][wr_idx] <= 1'b1;
            if (bus_addr == ADDR_W'(OFS_MSK_CLR)) mask_o[bus_cpu][wr_idx] <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/mcic_arb.sv
module mcic_arb
   import mcic_pkg::*;
#(
   parameter int NUM_SRCS = 32
) (
   input  logic [NUM_SRCS-1:0] pend_i,
   output logic [ID_W-1:0]     id_o
);
   // descending scan: the last hit is the lowest index
   always_comb begin
      id_o = ID_NONE;
      for (int i = NUM_SRCS - 1; i >= 0; i--) begin
         if (pend_i[i]) id_o = ID_W'(i);
      end
   end
endmodule

// File: rtl/mcic_top.sv
module mcic_top
   import mcic_pkg::*;
#(
   parameter int NUM_CPUS  = 4,
   parameter int NUM_SRCS  = 32,
   parameter int TIMER_SRC = 5,
   parameter int ADDR_W    = 12,
   parameter int DATA_W    = 32,
   localparam int CPU_W    = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                bus_valid,
   input  logic                bus_write,
   input  logic                bus_percpu,
   input  logic [CPU_W-1:0]    bus_cpu,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [DATA_W-1:0]   bus_wdata,
   output logic                rd_valid,
   output logic [DATA_W-1:0]   rd_data,
   input  logic [NUM_SRCS-1:0] src_i,
   input  logic [NUM_CPUS-1:0] doorbell_i,
   output logic [NUM_CPUS-1:0] cpu_irq_o
);
   localparam int SRC_W = (NUM_SRCS > 1) ? $clog2(NUM_SRCS) : 1;

   if (NUM_CPUS < 1 || NUM_CPUS > 4) begin : g_bad_cpus
      $error("mcic_top: NUM_CPUS must be 1..4");
   end
   if (NUM_SRCS < 2 || NUM_SRCS > 1023) begin : g_bad_srcs
      $error("mcic_top: NUM_SRCS must be 2..1023");
   end
   if (TIMER_SRC < 1 || TIMER_SRC >= NUM_SRCS) begin : g_bad_timer
      $error("mcic_top: TIMER_SRC out of range");
   end
   if (DATA_W < 12 || ADDR_W < SRC_W + 3 || (1 << ADDR_W) < OFS_ROUTE + 4 * NUM_SRCS) begin : g_bad_bus
      $error("mcic_top: bus widths too small");
   end

   logic [NUM_SRCS-1:0]               en;
   logic [NUM_CPUS-1:0][NUM_SRCS-1:0] mask;
   logic [NUM_SRCS-1:0][NUM_CPUS-1:0] route;
   logic                              route_hit;
   logic [NUM_CPUS-1:0]               route_sel;
   logic [NUM_CPUS-1:0][ID_W-1:0]     ack_id;
   logic [DATA_W-1:0]                 rd_mux;

   mcic_regs #(
      .NUM_CPUS(NUM_CPUS), .NUM_SRCS(NUM_SRCS), .ADDR_W(ADDR_W),
      .DATA_W(DATA_W), .CPU_W(CPU_W), .SRC_W(SRC_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(bus_valid && bus_write),
      .bus_percpu(bus_percpu), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .en_o(en), .mask_o(mask), .route_o(route),
      .route_hit_o(route_hit), .route_sel_o(route_sel)
   );

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
      logic [NUM_SRCS-1:0] pend;
      for (genvar s = 0; s < NUM_SRCS; s++) begin : g_src
         if (s == 0) begin : g_bell
            assign pend[s] = doorbell_i[c];
         end else if (s == TIMER_SRC) begin : g_timer
            assign pend[s] = src_i[s] && !mask[c][s];
         end else begin : g_norm
            assign pend[s] = src_i[s] && en[s] && route[s][c] && !mask[c][s];
         end
      end
      mcic_arb #(.NUM_SRCS(NUM_SRCS)) i_arb (.pend_i(pend), .id_o(ack_id[c]));
      assign cpu_irq_o[c] = |pend;
   end

   always_comb begin
      rd_mux = '0;
      if (!bus_percpu) begin
         if (bus_addr == ADDR_W'(OFS_CTRL)) rd_mux = DATA_W'(NUM_SRCS) << 2;
         else if (route_hit)                rd_mux = DATA_W'(route_sel);
      end else if (bus_addr == ADDR_W'(OFS_ACK) && int'(bus_cpu) < NUM_CPUS) begin
         rd_mux = DATA_W'(ack_id[bus_cpu]);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= bus_valid && !bus_write;
         rd_data  <= rd_mux;
      end
   end
endmodule

// File: rtl/mcic_chk.sv
module mcic_chk
   import mcic_pkg::*;
#(
   parameter int NUM_CPUS = 4,
   parameter int NUM_SRCS = 32,
   parameter int ADDR_W   = 12,
   parameter int DATA_W   = 32,
   parameter int CPU_W    = 2
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_valid,
   input logic                bus_write,
   input logic                bus_percpu,
   input logic [CPU_W-1:0]    bus_cpu,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic                rd_valid,
   input logic [DATA_W-1:0]   rd_data,
   input logic [NUM_SRCS-1:0] src_i,
   input logic [NUM_CPUS-1:0] doorbell_i,
   input logic [NUM_CPUS-1:0] cpu_irq_o
);
   logic rd_req, ack_rd, ctrl_rd, bell_hit;
   assign rd_req   = bus_valid && !bus_write;
   assign ack_rd   = rd_req && bus_percpu && bus_addr == ADDR_W'(OFS_ACK);
   assign ctrl_rd  = rd_req && !bus_percpu && bus_addr == ADDR_W'(OFS_CTRL);
   assign bell_hit = |(doorbell_i & (NUM_CPUS'(1) << bus_cpu));

   // R11
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   // R11
   no_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);
   // R9
   idle_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_i == '0 && doorbell_i == '0) |-> cpu_irq_o == '0);
   // R7
   bell_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_rd && bell_hit) |=> rd_data == '0);
   // R8
   ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_rd |=> (rd_data[DATA_W-1:ID_W] == '0) &&
                 (rd_data[ID_W-1:0] == ID_NONE || rd_data < DATA_W'(NUM_SRCS)));
   // R10
   ctrl_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_rd |=> rd_data[11:2] == 10'(NUM_SRCS));

   for (genvar c = 0; c < NUM_CPUS; c++) begin : g_bell
      // R7
      bell_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
         doorbell_i[c] |-> cpu_irq_o[c]);
   end
endmodule

bind mcic_top mcic_chk #(
   .NUM_CPUS(NUM_CPUS), .NUM_SRCS(NUM_SRCS), .ADDR_W(ADDR_W),
   .DATA_W(DATA_W), .CPU_W(CPU_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_percpu(bus_percpu), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
   .rd_valid(rd_valid), .rd_data(rd_data), .src_i(src_i),
   .doorbell_i(doorbell_i), .cpu_irq_o(cpu_irq_o)
);

// File: tb/test_mcic_top.sv
module test_mcic_top;
   localparam int CLK_P = 10;
   localparam int NC = 4;
   localparam int NS = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            bus_valid = 1'b0, bus_write = 1'b0, bus_percpu = 1'b0;
   logic [1:0]      bus_cpu = '0;
   logic [11:0]     bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic            rd_valid;
   logic [31:0]     rd_data;
   logic [NS-1:0]   src_i = '0;
   logic [NC-1:0]   doorbell_i = '0;
   logic [NC-1:0]   cpu_irq_o;

   int tests = 0, fails = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_P/2) clk = ~clk;

   mcic_top #(.NUM_CPUS(NC), .NUM_SRCS(NS)) i_mcic_top (
      .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
      .bus_percpu(bus_percpu), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
      .src_i(src_i), .doorbell_i(doorbell_i), .cpu_irq_o(cpu_irq_o)
   );

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // monitor: pop expected read data as responses arrive
   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) check(1'b0, "R11 unexpected response", rd_data, 32'h0);
         else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
         end
      end
   end

   task automatic bus_wr(bit pc, int cpu, int addr, int data);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b1; bus_percpu = pc;
      bus_cpu = 2'(cpu); bus_addr = 12'(addr); bus_wdata = 32'(data);
      @(negedge clk);
      bus_valid = 1'b0; bus_write = 1'b0;
      @(negedge clk);
      check(rd_valid == 1'b0, "R11 write gives no response", 32'(rd_valid), 32'h0);
   endtask

   task automatic bus_rd(bit pc, int cpu, int addr, logic [31:0] exp, string tag);
      @(negedge clk);
      bus_valid = 1'b1; bus_write = 1'b0; bus_percpu = pc;
      bus_cpu = 2'(cpu); bus_addr = 12'(addr);
      exp_q.push_back(exp); tag_q.push_back(tag);
      @(negedge clk);
      bus_valid = 1'b0;
   endtask

   task automatic ack(int cpu, int exp, string tag);
      bus_rd(1'b1, cpu, 'h44, 32'(exp), tag);
   endtask

   task automatic irq(logic [NC-1:0] exp, string tag);
      @(negedge clk);
      check(cpu_irq_o === exp, tag, 32'(cpu_irq_o), 32'(exp));
   endtask

   task automatic route(int n, int bits);
      bus_wr(1'b0, 0, 'h100 + 4*n, bits);
   endtask

   initial begin
      #(CLK_P * 100000);
      check(1'b0, "watchdog expired", 32'h0, 32'h0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      src_i = '1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      irq(4'b0000, "R1 irq low after reset");
      for (int c = 0; c < NC; c++) ack(c, 1023, "R1 ack none after reset");
      bus_rd(1'b0, 0, 'h10C, 32'h0, "R1 route word reset");
      // R10
      bus_rd(1'b0, 0, 'h000, 32'(NS << 2), "R10 control word");
      src_i = '0;
      // R3 routing read-back
      route(3, 'h1);
      bus_rd(1'b0, 0, 'h10C, 32'h1, "R3 route 3 readback");
      route(7, 'hFF);
      bus_rd(1'b0, 0, 'h11C, 32'hF, "R3 route bits trimmed");
      route(7, 'h6);
      bus_rd(1'b0, 0, 'h11C, 32'h6, "R3 route 7 readback");
      // R5 basic pending
      bus_wr(1'b0, 0, 'h30, 3);
      bus_wr(1'b1, 0, 'h4C, 3);
      src_i[3] = 1'b1;
      irq(4'b0001, "R5 src3 to cpu0");
      ack(0, 3, "R5 cpu0 acks 3");
      ack(1, 1023, "R3 cpu1 not routed");
      bus_wr(1'b0, 0, 'h30, 7);
      for (int c = 0; c < 3; c++) bus_wr(1'b1, c, 'h4C, 7);
      src_i[7] = 1'b1;
      irq(4'b0111, "R3 src7 to cpu1 cpu2");
      ack(0, 3, "R3 cpu0 ignores unrouted 7");
      ack(1, 7, "R5 cpu1 acks 7");
      // R8 lowest wins
      route(7, 'h7);
      ack(0, 3, "R8 lowest of 3 and 7");
      src_i[3] = 1'b0;
      ack(0, 7, "R5 level drop exposes 7");
      // R4 per-CPU mask
      bus_wr(1'b1, 1, 'h48, 7);
      ack(1, 1023, "R4 cpu1 masked 7");
      ack(2, 7, "R4 cpu2 unaffected");
      irq(4'b0101, "R9 irq after mask");
      // R2 clear enable only for the named source
      bus_wr(1'b0, 0, 'h34, 7);
      irq(4'b0000, "R2 disable 7");
      src_i[3] = 1'b1;
      ack(0, 3, "R2 source 3 still enabled");
      // R6 timer
      src_i[5] = 1'b1;
      bus_wr(1'b1, 2, 'h4C, 5);
      ack(2, 5, "R6 timer without enable or route");
      ack(0, 3, "R6 timer masked on cpu0");
      src_i[3] = 1'b0;
      ack(0, 1023, "R6 cpu0 timer masked");
      irq(4'b0100, "R9 only cpu2");
      bus_wr(1'b0, 0, 'h34, 5);
      ack(2, 5, "R6 enable clear ignored by timer");
      ack(1, 1023, "R6 cpu1 timer masked");
      // R7 doorbell
      doorbell_i[2] = 1'b1;
      ack(2, 0, "R7 doorbell beats timer");
      doorbell_i[3] = 1'b1;
      irq(4'b1100, "R9 doorbell irq");
      ack(3, 0, "R7 cpu3 doorbell");
      doorbell_i = '0;
      irq(4'b0100, "R7 doorbell released");
      // R12 source 0 ignored
      src_i[0] = 1'b1;
      bus_wr(1'b0, 0, 'h30, 0);
      route(0, 'hF);
      bus_wr(1'b1, 3, 'h4C, 0);
      ack(3, 1023, "R12 source 0 never pending");
      irq(4'b0100, "R12 no irq from source 0");
      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R11 all reads answered", 32'(exp_q.size()), 32'h0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule